// File: doc/BRIEF.md
# FIFO-buffered PWM controller

A single-channel pulse-width modulator that software programs through a small word-addressed register port. Duty values ("samples") are not applied when they are written. They are queued in a four-entry FIFO, and the modulator takes the next one only at the boundary between two periods. A period lasts the period-register value plus two counter ticks. The counter tick comes from a selectable source and passes through a programmable prescaler. Each sample can be held for 1, 2, 4 or 8 consecutive periods. When the queue runs dry, the last sample stays in force.

Because every new sample waits for the current period to expire, a shorter duty can never appear in the middle of a period. The output therefore always makes its falling transition, and the queue-empty case cannot produce a stray full-high period. A self-clearing soft-reset bit returns every register and the queue to the reset state.

Register word map (`bus_addr`): 0 control, 1 status, 2 sample (write pushes, read shows the active sample), 3 period, 4 counter (read-only).

Top module: `pwm_fifo_ctrl`

## Requirements
- R1: One output period lasts period+2 counter ticks. The counter reads 0 up to period+1 and then returns to 0. A period register of 0xFFFF behaves exactly like 0xFFFE, and it still reads back as written.
- R2: The output level is high while counter < active sample. A sample of 0 keeps it low for the whole period. A sample at or above period+2 keeps it high for the whole period.
- R3: Samples queue in a 4-entry FIFO. Status[2:0] gives the fill level (0 to 4), status[3] flags empty, and status[7] is set while fill <= control[9:8]. A sample write to a full FIFO is dropped and sets status[6].
- R4: While control[0] (enable) is 0, pwm_out is 0. Control[5:4] selects the output: 0 normal, 1 inverted, 2 or 3 held low.
- R5: Control[27:16] divides the tick source by its value plus 1. Control[7:6] picks the source: 0 stopped, 1 or 2 every clock, 3 each clock in which slow_tick is high.
- R6: Control[3:2] = 0, 1, 2, 3 keeps each sample for 1, 2, 4 or 8 periods. At a boundary with an empty FIFO, the active sample is reused.
- R7: A sample write never changes the duty inside the current period, even into an empty FIFO. It takes effect at the next boundary.
- R8: Reading the sample word returns the active sample while enabled and 0 while disabled.
- R9: Writing 1 to control[1] starts a soft reset. Control[1] reads 1 for SRST_CYCLES clocks and then 0, and afterwards every register and the FIFO hold their reset values.
- R10: Status[4] latches each rollover and status[5] latches each counter match with the active sample. Writing 1 to a status bit clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| slow_tick | input | 1 | External tick for clock select 3 |
| pwm_out | output | 1 | Modulated output |

## Verification
A scoreboard counts high cycles in each period window and compares them with the expected duty. The sample sequences are chosen to separate cases. A mid-range sample followed by zero and by an oversized value distinguishes the compare point from the two saturated extremes. A FIFO drained in front of repeated boundaries shows reuse of the last sample, as opposed to a drop to zero. A repeat factor of two with two queued samples shows that the repeat counter gates the pop. The hazard case writes a smaller sample into an empty FIFO in the middle of a long-duty period. A design that applied the write at once would cut that period short, so the check separates deferred update from immediate update. Prescaled, stopped and externally ticked runs, together with a run at the all-ones period, check the tick path and the clamp through the counter readback.

// File: rtl/pwm_fifo_ctrl.sv
module pwm_fifo_ctrl #(
  parameter int DW          = 16,
  parameter int DEPTH       = 4,
  parameter int PSW         = 12,
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        slow_tick,
  output logic        pwm_out
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(SRST_CYCLES + 1);
  localparam logic [DW-1:0] PMAX = '1;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_SAMP = 3'd2;
  localparam logic [2:0] A_PER  = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  logic           en;
  logic [1:0]     rep_sel, outsel, clksel, wmark;
  logic [PSW-1:0] presc, pcnt;
  logic [DW-1:0]  period_r, active, cnt;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [FW-1:0]  fill;
  logic [2:0]     rep_cnt, rep_last;
  logic           running;
  logic           f_roll, f_cmp, f_werr;
  logic [SW-1:0]  srst_cnt;

  logic           busy, wr, push, wr_full, start, src_tick, tick, roll, pop, level;
  logic [DW-1:0]  pr_eff, last;

  assign busy     = srst_cnt != '0;
  assign wr       = bus_sel && bus_wr && !busy;
  assign wr_full  = wr && bus_addr == A_SAMP && fill == FW'(DEPTH);
  assign push     = wr && bus_addr == A_SAMP && fill != FW'(DEPTH);
  assign pr_eff   = (period_r == PMAX) ? PMAX - DW'(1) : period_r;
  assign last     = pr_eff + DW'(1);
  assign src_tick = (clksel == 2'd0) ? 1'b0 : (clksel == 2'd3) ? slow_tick : 1'b1;
  assign tick     = running && src_tick && pcnt == presc;
  assign start    = en && !running;
  assign roll     = tick && cnt >= last;
  assign pop      = (start || (roll && rep_cnt == rep_last)) && fill != '0;
  assign level    = cnt < active;

  always_comb begin
    case (rep_sel)
      2'd0:    rep_last = 3'd0;
      2'd1:    rep_last = 3'd1;
      2'd2:    rep_last = 3'd3;
      default: rep_last = 3'd7;
    endcase
  end

  always_comb begin
    pwm_out = 1'b0;
    if (en && running) begin
      if (outsel == 2'd0)      pwm_out = level;
      else if (outsel == 2'd1) pwm_out = !level;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'({presc, 6'b0, wmark, clksel, outsel, rep_sel, busy, en});
      A_STAT:  bus_rdata = 32'({(fill <= FW'(wmark)), f_werr, f_cmp, f_roll, (fill == '0), 3'(fill)});
      A_SAMP:  bus_rdata = en ? 32'(active) : 32'd0;
      A_PER:   bus_rdata = 32'(period_r);
      A_CNT:   bus_rdata = 32'(cnt);
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   srst_cnt <= '0;
    else if (busy)                                srst_cnt <= srst_cnt - SW'(1);
    else if (wr && bus_addr == A_CTRL && bus_wdata[1]) srst_cnt <= SW'(SRST_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= bus_wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rep_sel <= '0; outsel <= '0; clksel <= '0; wmark <= '0;
      presc <= '0; period_r <= PMAX - DW'(1);
      rd_ptr <= '0; wr_ptr <= '0; fill <= '0;
      active <= '0; cnt <= '0; pcnt <= '0; rep_cnt <= '0; running <= 1'b0;
      f_roll <= 1'b0; f_cmp <= 1'b0; f_werr <= 1'b0;
    end else if (busy) begin
      en <= 1'b0; rep_sel <= '0; outsel <= '0; clksel <= '0; wmark <= '0;
      presc <= '0; period_r <= PMAX - DW'(1);
      rd_ptr <= '0; wr_ptr <= '0; fill <= '0;
      active <= '0; cnt <= '0; pcnt <= '0; rep_cnt <= '0; running <= 1'b0;
      f_roll <= 1'b0; f_cmp <= 1'b0; f_werr <= 1'b0;
    end else begin
      if (wr && bus_addr == A_CTRL) begin
        en      <= bus_wdata[0];
        rep_sel <= bus_wdata[3:2];
        outsel  <= bus_wdata[5:4];
        clksel  <= bus_wdata[7:6];
        wmark   <= bus_wdata[9:8];
        presc   <= bus_wdata[16 +: PSW];
      end
      if (wr && bus_addr == A_PER) period_r <= bus_wdata[DW-1:0];

      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        active <= mem[rd_ptr];
      end
      fill <= fill + FW'(push) - FW'(pop);

      if (!en) begin
        running <= 1'b0;
        cnt     <= '0;
        pcnt    <= '0;
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        pcnt    <= '0;
        rep_cnt <= '0;
      end else begin
        if (src_tick) pcnt <= (pcnt == presc) ? '0 : pcnt + PSW'(1);
        if (tick) cnt <= roll ? '0 : cnt + DW'(1);
        if (roll) rep_cnt <= (rep_cnt == rep_last) ? 3'd0 : rep_cnt + 3'd1;
      end

      f_roll <= (f_roll & !(wr && bus_addr == A_STAT && bus_wdata[4])) | roll;
      f_cmp  <= (f_cmp  & !(wr && bus_addr == A_STAT && bus_wdata[5]))
              | (tick && !roll && (cnt + DW'(1)) == active);
      f_werr <= (f_werr & !(wr && bus_addr == A_STAT && bus_wdata[6])) | wr_full;
    end
  end

  // R3: fill level never exceeds the queue depth
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R3: a dropped write raises the error flag on the next cycle
  a_r3_full_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !busy && bus_addr == A_SAMP && fill == FW'(DEPTH)) |=> f_werr);

  // R4: disabled output stays low
  a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  // R2: zero sample with normal polarity never drives high
  a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0 && outsel == 2'd0) |-> !pwm_out);

  // R7: the active sample changes only together with a period start
  a_r7_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && active != $past(active)) |-> cnt == '0);
endmodule

// File: tb/test_pwm_fifo_ctrl.sv
module test_pwm_fifo_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slow_tick = 1'b0;
  logic        pwm_out;

  int total = 0;
  int fails = 0;
  int exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_fifo_ctrl i_pwm_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_tick(slow_tick), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic push_exp(input int hi, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(hi);
  endtask

  task automatic run_periods(input string req, input int n, input int len);
    for (int p = 0; p < n; p++) begin
      int hi = 0;
      int e;
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (pwm_out) hi++;
      end
      e = exp_q.pop_front();
      chk(req, 32'(hi), 32'(e));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R4 reset output", 32'(pwm_out), 0);
    bus_read(3'd1, d); chk("R3 reset status", d, 32'h88);
    bus_read(3'd0, d); chk("R9 reset control", d, 0);
    bus_read(3'd3, d); chk("R1 reset period", d, 32'hFFFE);

    // R3: overfill, R8 readback while disabled
    for (int i = 1; i <= 5; i++) bus_write(3'd2, 32'(i));
    bus_read(3'd1, d); chk("R3 full + write error", d, 32'h44);
    bus_read(3'd2, d); chk("R8 disabled readback", d, 0);

    // R9 soft reset
    bus_write(3'd0, 32'h2);
    bus_read(3'd0, d); chk("R9 busy bit", d, 32'h2);
    repeat (6) @(negedge clk);
    bus_read(3'd0, d); chk("R9 bit cleared", d, 0);
    bus_read(3'd1, d); chk("R9 fifo cleared", d, 32'h88);

    // R1/R2: period 8 -> 10 ticks; samples 3, 0, 12 then reuse
    bus_write(3'd3, 8);
    bus_write(3'd2, 3); bus_write(3'd2, 0); bus_write(3'd2, 12);
    push_exp(3, 1); push_exp(0, 1); push_exp(10, 2);
    bus_write(3'd0, 32'h41);
    run_periods("R2 duty sequence", 4, 10);
    bus_read(3'd2, d); chk("R8 enabled readback", d, 12);
    bus_write(3'd0, 32'h40);
    chk("R4 disabled low", 32'(pwm_out), 0);
    bus_read(3'd1, d); chk("R10 flags set", d, 32'hB8);
    bus_write(3'd1, 32'h30);
    bus_read(3'd1, d); chk("R10 flags cleared", d, 32'h88);

    // R7: smaller sample written mid-period into an empty FIFO
    bus_write(3'd2, 8);
    push_exp(8, 1); push_exp(3, 2);
    bus_write(3'd0, 32'h41);
    fork
      run_periods("R7 deferred update", 3, 10);
      begin repeat (5) @(negedge clk); bus_write(3'd2, 3); end
    join
    bus_write(3'd0, 32'h40);

    // R6: repeat x2
    bus_write(3'd2, 2); bus_write(3'd2, 5);
    push_exp(2, 2); push_exp(5, 3);
    bus_write(3'd0, 32'h45);
    run_periods("R6 repeat and reuse", 5, 10);
    bus_write(3'd0, 32'h40);

    // R4 inverted and disconnected
    bus_write(3'd2, 3);
    push_exp(7, 2);
    bus_write(3'd0, 32'h51);
    run_periods("R4 inverted", 2, 10);
    bus_write(3'd0, 32'h50);
    chk("R4 inverted disabled low", 32'(pwm_out), 0);
    push_exp(0, 2);
    bus_write(3'd0, 32'h61);
    run_periods("R4 disconnected", 2, 10);
    bus_write(3'd0, 32'h40);

    // R5 prescaler /3, period 2 -> 4 ticks = 12 clocks
    bus_write(3'd3, 2);
    bus_write(3'd2, 2);
    push_exp(6, 2);
    bus_write(3'd0, 32'h20041);
    run_periods("R5 prescaler", 2, 12);
    bus_write(3'd0, 32'h40);

    // R5 stopped source and external tick
    bus_write(3'd3, 8);
    bus_write(3'd0, 32'h01);
    repeat (3) @(negedge clk);
    bus_read(3'd4, d); chk("R5 stopped source", d, 0);
    bus_write(3'd0, 32'h00);
    bus_write(3'd0, 32'hC1);
    repeat (3) @(negedge clk);
    bus_read(3'd4, d); chk("R5 external tick idle", d, 0);
    slow_tick = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(3'd4, d); chk("R5 external tick count", d, 3);
    slow_tick = 1'b0;
    bus_write(3'd0, 32'h40);

    // R1 clamp: 0xFFFF behaves as 0xFFFE
    bus_write(3'd3, 32'hFFFF);
    bus_read(3'd3, d); chk("R1 period readback", d, 32'hFFFF);
    bus_write(3'd0, 32'h41);
    repeat (32'hFFFF) @(negedge clk);
    bus_read(3'd4, d); chk("R1 counter top", d, 32'hFFFF);
    bus_read(3'd4, d); chk("R1 counter wraps", d, 0);
    bus_write(3'd0, 32'h40);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule